// File: doc/BRIEF.md
# Programmable Frequency Synthesizer Divider Core

This block holds the digital half of a tuner frequency synthesizer. A fixed halving stage ahead of it feeds it one tick per prescaled oscillator period. It divides that tick stream by a programmable 16-bit ratio N with a dual-modulus pulse-swallow counter: a 32/33 prescaler, a main counter and a swallow counter, where N = 32·P + A. A second counter divides a crystal tick stream by 64 or 128. So the synthesized frequency is twice the comparison frequency times N.

The two divided pulses meet in a two-flop phase-frequency detector. The detector drives source and sink enables for an external charge pump and flags lock once the two edges stay close for a run of comparisons. A 3-bit test code can force the pump to source only, sink only or off. It can also route either divided pulse to a monitor output. A tuning-disable input silences the pump. The 2-bit pump-current code goes straight through to the analog side.

Both tick streams enter as single-cycle strobes that are synchronous to one system clock. The system clock runs faster than either tick stream, so the whole core sits in one clock domain.

Top module: `synth_divider_core`

## Requirements
- R1: With ticks arriving steadily, a divided pulse occurs once per N ticks for any N from 1024 to 65535. The low 5 bits of N (A) give the number of 33-tick prescaler periods. The upper 11 bits (P) give the total number of prescaler periods.
- R2: After reset all counters start from zero, so the first divided pulse follows exactly N ticks.
- R3: The reference counter emits one pulse per 128 crystal ticks when `ref_fast_i`=0 and one per 64 when `ref_fast_i`=1.
- R4: A reference pulse raises the source enable and a divided pulse raises the sink enable. When both are up they are cleared together, so the enable that stays up does so for exactly the clock offset between the two pulses. In test codes 000, 001, 100 and 101 the pump outputs follow the detector.
- R5: Test codes 010 and 011 hold both pump outputs low.
- R6: Test code 110 holds sink high and source low. Test code 111 holds source high and sink low. Source and sink are never high together.
- R7: Test code 100 copies the reference pulse to `mon_o`. Test code 101 copies the divided pulse to it. Every other code holds `mon_o` low.
- R8: `tune_off_i`=1 holds both pump outputs low whatever the test code.
- R9: `pump_cur_o` always equals `cp_code_i`.
- R10: `locked_o` rises after 16 consecutive comparisons whose edge offset is at most 4 clocks.
- R11: Once an enable has been up for 5 clocks, `locked_o` drops on the next edge and the run restarts.
- R12: During and right after reset, the pump, lock and monitor outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vco_tick_i | input | 1 | One-cycle strobe per prescaled oscillator period |
| xtal_tick_i | input | 1 | One-cycle strobe per crystal period |
| ratio_i | input | 16 | Programmable divide ratio N |
| ref_fast_i | input | 1 | 1: reference divide by 64, 0: by 128 |
| tune_off_i | input | 1 | 1: pump outputs disabled |
| cp_code_i | input | 2 | Pump current code |
| test_code_i | input | 3 | Test mode code |
| pump_src_o | output | 1 | Charge-pump source enable |
| pump_snk_o | output | 1 | Charge-pump sink enable |
| pump_cur_o | output | 2 | Pump current code to the analog side |
| locked_o | output | 1 | Lock flag |
| mon_o | output | 1 | Monitor output |

## Verification
The bench builds the core with its default parameters: a 16-bit ratio with a 5-bit swallow field, a 64/128 reference counter, a lock tolerance of 4 clocks and a run of 16. With these defaults the largest ratio, 65535, can be timed from reset inside the run. The lock test sets the edge offset to exactly 4 clocks so that lock must build, and then slips it to 5 so that lock must fall. A ratio of 1055 exercises a full swallow field of 31 against the minimum main count.

// File: rtl/synth_div_pkg.sv
package synth_div_pkg;

    typedef enum logic [2:0] {
        TC_RUN_A   = 3'b000,
        TC_RUN_B   = 3'b001,
        TC_MUTE_A  = 3'b010,
        TC_MUTE_B  = 3'b011,
        TC_SHOW_RF = 3'b100,
        TC_SHOW_DV = 3'b101,
        TC_SINK    = 3'b110,
        TC_SOURCE  = 3'b111
    } test_code_e;

    typedef struct packed {
        logic follow;     // pump follows the detector
        logic force_src;
        logic force_snk;
        logic show_ref;
        logic show_div;
    } test_ctl_t;

    function automatic test_ctl_t decode_test(input logic [2:0] code);
        test_ctl_t c;
        c = '0;
        case (test_code_e'(code))
            TC_RUN_A, TC_RUN_B:   c.follow = 1'b1;
            TC_SHOW_RF:           begin c.follow = 1'b1; c.show_ref = 1'b1; end
            TC_SHOW_DV:           begin c.follow = 1'b1; c.show_div = 1'b1; end
            TC_SINK:              c.force_snk = 1'b1;
            TC_SOURCE:            c.force_src = 1'b1;
            default:              c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/swallow_div.sv
module swallow_div #(
    parameter int RATIO_W = 16,
    parameter int SWAL_W  = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_i,
    input  logic [RATIO_W-1:0] ratio_i,
    output logic               pulse_o
);
    localparam int PRE_W  = SWAL_W + 1;
    localparam int MAIN_W = RATIO_W - SWAL_W;
    localparam logic [PRE_W-1:0] LAST_LO = PRE_W'((1 << SWAL_W) - 1);
    localparam logic [PRE_W-1:0] LAST_HI = PRE_W'(1 << SWAL_W);

    typedef struct packed {
        logic [PRE_W-1:0]  pre;
        logic [MAIN_W-1:0] main;
        logic              pulse;
    } st_t;

    st_t st_q, st_d;
    logic [MAIN_W-1:0] main_last;
    logic [MAIN_W-1:0] swal_n;
    logic              swallow;
    logic [PRE_W-1:0]  pre_last;

    always_comb begin
        main_last = ratio_i[RATIO_W-1:SWAL_W] - MAIN_W'(1);
        swal_n    = MAIN_W'(ratio_i[SWAL_W-1:0]);
        swallow   = st_q.main < swal_n;
        pre_last  = swallow ? LAST_HI : LAST_LO;
        st_d       = st_q;
        st_d.pulse = 1'b0;
        if (tick_i) begin
            if (st_q.pre >= pre_last) begin
                st_d.pre = '0;
                if (st_q.main >= main_last) begin
                    st_d.main  = '0;
                    st_d.pulse = 1'b1;
                end else begin
                    st_d.main = st_q.main + MAIN_W'(1);
                end
            end else begin
                st_d.pre = st_q.pre + PRE_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pulse_o = st_q.pulse;

    // R1: a divided pulse is always caused by a consumed tick
    assert_pulse_needs_tick_R1: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pulse |-> $past(tick_i));
    // R1: the prescaler never counts beyond the 33-tick modulus
    assert_prescale_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pre <= LAST_HI);
    // R2: every pulse leaves the counters back at their start state
    assert_pulse_restarts_R2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pulse |-> (st_q.pre == '0 && st_q.main == '0));

endmodule

// File: rtl/ref_div.sv
module ref_div #(
    parameter int REF_LOG2 = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic fast_i,
    output logic pulse_o
);
    localparam int CNT_W = REF_LOG2 + 1;
    localparam logic [CNT_W-1:0] LAST_FAST = CNT_W'((1 << REF_LOG2) - 1);
    localparam logic [CNT_W-1:0] LAST_SLOW = CNT_W'((1 << (REF_LOG2 + 1)) - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             pulse;
    } st_t;

    st_t st_q, st_d;
    logic [CNT_W-1:0] last;

    always_comb begin
        last       = fast_i ? LAST_FAST : LAST_SLOW;
        st_d       = st_q;
        st_d.pulse = 1'b0;
        if (tick_i) begin
            if (st_q.cnt >= last) begin
                st_d.cnt   = '0;
                st_d.pulse = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pulse_o = st_q.pulse;

    // R3: reference pulses come only from a consumed crystal tick
    assert_ref_needs_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pulse |-> $past(tick_i));
    // R3: a reference pulse leaves the count at zero
    assert_ref_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pulse |-> st_q.cnt == '0);

endmodule

// File: rtl/pfd_lock.sv
module pfd_lock #(
    parameter int LOCK_TOL = 4,
    parameter int LOCK_RUN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_pulse_i,
    input  logic div_pulse_i,
    output logic up_o,
    output logic dn_o,
    output logic lock_o
);
    localparam int WID_W  = $clog2(LOCK_TOL + 1);
    localparam int GOOD_W = $clog2(LOCK_RUN + 1);
    localparam logic [WID_W-1:0]  TOL_V = WID_W'(LOCK_TOL);
    localparam logic [GOOD_W-1:0] RUN_V = GOOD_W'(LOCK_RUN);

    typedef struct packed {
        logic              up;
        logic              dn;
        logic [WID_W-1:0]  wid;
        logic [GOOD_W-1:0] good;
        logic              lock;
    } st_t;

    st_t  st_q, st_d;
    logic up_n, dn_n, both, active, slip, match;

    always_comb begin
        up_n   = st_q.up | ref_pulse_i;
        dn_n   = st_q.dn | div_pulse_i;
        both   = up_n & dn_n;
        active = st_q.up | st_q.dn;
        slip   = active && (st_q.wid >= TOL_V);
        match  = both && !slip;

        st_d    = st_q;
        st_d.up = up_n & ~both;
        st_d.dn = dn_n & ~both;

        if (both || !active)          st_d.wid = '0;
        else if (st_q.wid < TOL_V)    st_d.wid = st_q.wid + WID_W'(1);

        if (slip)                     st_d.good = '0;
        else if (match && st_q.good < RUN_V)
                                      st_d.good = st_q.good + GOOD_W'(1);

        st_d.lock = (st_d.good == RUN_V);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign up_o   = st_q.up;
    assign dn_o   = st_q.dn;
    assign lock_o = st_q.lock;

    // R4: the two detector flops are never set together
    assert_flops_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_q.up && st_q.dn));
    // R11: an enable held for the tolerance and more drops lock next cycle
    assert_slip_unlocks_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.up || st_q.dn) && st_q.wid >= TOL_V) |=> !st_q.lock);
    // R10: lock is only gained on the cycle after a comparison closed
    assert_lock_on_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.lock) |-> (!st_q.up && !st_q.dn));

endmodule

// File: rtl/synth_divider_core.sv
module synth_divider_core
    import synth_div_pkg::*;
#(
    parameter int RATIO_W  = 16,
    parameter int SWAL_W   = 5,
    parameter int REF_LOG2 = 6,
    parameter int LOCK_TOL = 4,
    parameter int LOCK_RUN = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               vco_tick_i,
    input  logic               xtal_tick_i,
    input  logic [RATIO_W-1:0] ratio_i,
    input  logic               ref_fast_i,
    input  logic               tune_off_i,
    input  logic [1:0]         cp_code_i,
    input  logic [2:0]         test_code_i,
    output logic               pump_src_o,
    output logic               pump_snk_o,
    output logic [1:0]         pump_cur_o,
    output logic               locked_o,
    output logic               mon_o
);
    logic      div_pulse, ref_pulse, pfd_up, pfd_dn;
    test_ctl_t ctl;

    swallow_div #(.RATIO_W(RATIO_W), .SWAL_W(SWAL_W)) u_swallow (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (vco_tick_i),
        .ratio_i (ratio_i),
        .pulse_o (div_pulse)
    );

    ref_div #(.REF_LOG2(REF_LOG2)) u_ref (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (xtal_tick_i),
        .fast_i  (ref_fast_i),
        .pulse_o (ref_pulse)
    );

    pfd_lock #(.LOCK_TOL(LOCK_TOL), .LOCK_RUN(LOCK_RUN)) u_pfd (
        .clk         (clk),
        .rst_n       (rst_n),
        .ref_pulse_i (ref_pulse),
        .div_pulse_i (div_pulse),
        .up_o        (pfd_up),
        .dn_o        (pfd_dn),
        .lock_o      (locked_o)
    );

    always_comb begin
        ctl        = decode_test(test_code_i);
        pump_src_o = !tune_off_i && (ctl.force_src || (ctl.follow && pfd_up));
        pump_snk_o = !tune_off_i && (ctl.force_snk || (ctl.follow && pfd_dn));
        mon_o      = (ctl.show_ref && ref_pulse) || (ctl.show_div && div_pulse);
        pump_cur_o = cp_code_i;
    end

    // R8: tuning disable silences the pump
    assert_off_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tune_off_i |-> (!pump_src_o && !pump_snk_o));
    // R6: source and sink never drive together
    assert_pump_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(pump_src_o && pump_snk_o));
    // R7: monitor stays quiet outside the monitor codes
    assert_mon_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !test_code_i[2] |-> !mon_o);
    // R5: mute codes keep the pump idle
    assert_mute_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (test_code_i[2:1] == 2'b01) |-> (!pump_src_o && !pump_snk_o));

endmodule

// File: tb/synth_divider_core_bench.sv
module synth_divider_core_bench;
    localparam int CLK_PERIOD   = 10;
    localparam int WATCHDOG_CYC = 190000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        vco_tick = 1'b0, xtal_tick = 1'b0;
    logic [15:0] ratio = 16'd1024;
    logic        ref_fast = 1'b1, tune_off = 1'b0;
    logic [1:0]  cp_code = 2'd0;
    logic [2:0]  test_code = 3'd0;
    logic        pump_src, pump_snk, locked, mon;
    logic [1:0]  pump_cur;

    always #(CLK_PERIOD/2) clk = ~clk;

    synth_divider_core u_synth_divider_core (
        .clk(clk), .rst_n(rst_n), .vco_tick_i(vco_tick), .xtal_tick_i(xtal_tick),
        .ratio_i(ratio), .ref_fast_i(ref_fast), .tune_off_i(tune_off),
        .cp_code_i(cp_code), .test_code_i(test_code), .pump_src_o(pump_src),
        .pump_snk_o(pump_snk), .pump_cur_o(pump_cur), .locked_o(locked), .mon_o(mon)
    );

    int n_tests = 0, n_fail = 0;
    int gcyc = 0;
    bit vco_on = 0, ref_on = 0;
    int vco_start = 0, rphase = 0, ref_every = 1;
    logic s_src, s_snk, s_lock, s_mon;
    logic [1:0] s_cur;

    function automatic int exp_ref_ratio(input bit fast);
        return fast ? 64 : 128;
    endfunction

    // one drive-to-sample cycle sits between the N-th tick and its observation
    function automatic int exp_first_pulse(input int n);
        return n + 1;
    endfunction

    task automatic check(input string req, input string what, input int actual, input int expected);
        n_tests++;
        if (actual != expected) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, actual, expected);
        end
    endtask

    task automatic step();
        @(negedge clk);
        s_src = pump_src; s_snk = pump_snk; s_lock = locked; s_mon = mon; s_cur = pump_cur;
        vco_tick  = vco_on && (gcyc >= vco_start);
        xtal_tick = ref_on && (gcyc >= rphase) && (((gcyc - rphase) % ref_every) == 0);
        gcyc++;
    endtask

    task automatic run_to(input int target);
        while (gcyc < target) step();
    endtask

    task automatic do_reset();
        rst_n = 1'b0; vco_on = 0; ref_on = 0; vco_tick = 1'b0; xtal_tick = 1'b0;
        repeat (3) @(negedge clk);
        gcyc = 0;
        rst_n = 1'b1;
    endtask

    task automatic wait_mon(input int limit, output int cnt);
        cnt = 0;
        do begin
            step();
            cnt++;
        end while (!s_mon && cnt < limit);
    endtask

    initial begin
        repeat (WATCHDOG_CYC) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog R12: actual=%0d expected<%0d cycles", WATCHDOG_CYC, WATCHDOG_CYC);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int c, mons, snks, srcs;
        int unsigned seed;
        int ratios[4];
        seed = $urandom(32'd2718);

        // R12 reset state
        do_reset();
        step();
        check("R12", "pump_src after reset", int'(s_src), 0);
        check("R12", "pump_snk after reset", int'(s_snk), 0);
        check("R12", "locked after reset", int'(s_lock), 0);
        check("R12", "mon after reset", int'(s_mon), 0);

        // R2 first pulse from reset at the largest ratio
        ratio = 16'd65535; test_code = 3'b101;
        do_reset();
        vco_on = 1; vco_start = 0;
        wait_mon(70000, c);
        check("R2", "first pulse N=65535", c, exp_first_pulse(65535));

        // R1 steady intervals, directed and random ratios
        ratios[0] = 1024; ratios[1] = 1055;
        ratios[2] = 1024 + int'($urandom % 1024);
        ratios[3] = 1024 + int'($urandom % 1024);
        for (int i = 0; i < 4; i++) begin
            ratio = 16'(ratios[i]);
            wait_mon(70000, c);
            wait_mon(70000, c);
            check("R1", $sformatf("interval N=%0d", ratios[i]), c, ratios[i]);
        end

        // R9 current code passthrough
        for (int i = 0; i < 6; i++) begin
            int code;
            code = (i < 4) ? i : int'($urandom % 4);
            cp_code = 2'(code);
            step();
            check("R9", "pump_cur", int'(s_cur), code);
        end
        cp_code = 2'd0;

        // pump modes: reference running, oscillator stopped -> source stuck high
        do_reset();
        test_code = 3'b000; ratio = 16'd1024; ref_fast = 1'b1;
        ref_on = 1; ref_every = 1; rphase = 0;
        run_to(100);
        check("R4", "src with lead ref", int'(s_src), 1);
        check("R4", "snk with lead ref", int'(s_snk), 0);
        for (int i = 0; i < 2; i++) begin
            test_code = (i == 0) ? 3'b010 : 3'b011;
            step();
            check("R5", $sformatf("src mute code %0d", test_code), int'(s_src), 0);
            check("R5", $sformatf("snk mute code %0d", test_code), int'(s_snk), 0);
        end
        test_code = 3'b110; step();
        check("R6", "sink-only snk", int'(s_snk), 1);
        check("R6", "sink-only src", int'(s_src), 0);
        test_code = 3'b111; step();
        check("R6", "source-only src", int'(s_src), 1);
        check("R6", "source-only snk", int'(s_snk), 0);
        tune_off = 1'b1;
        for (int i = 0; i < 3; i++) begin
            test_code = (i == 0) ? 3'b111 : (i == 1) ? 3'b110 : 3'b000;
            step();
            check("R8", $sformatf("src off code %0d", test_code), int'(s_src), 0);
            check("R8", $sformatf("snk off code %0d", test_code), int'(s_snk), 0);
        end
        tune_off = 1'b0;
        test_code = 3'b100; step();
        check("R4", "src follows in monitor code", int'(s_src), 1);
        wait_mon(1000, c); wait_mon(1000, c);
        check("R3", "ref interval fast (R7 monitor)", c, exp_ref_ratio(1'b1));
        ref_fast = 1'b0;
        wait_mon(1000, c); wait_mon(1000, c);
        check("R3", "ref interval slow (R7 monitor)", c, exp_ref_ratio(1'b0));
        ref_fast = 1'b1;

        // oscillator running, reference stopped -> sink stuck high, monitor quiet
        do_reset();
        test_code = 3'b000; ratio = 16'd1024;
        vco_on = 1; vco_start = 0;
        mons = 0;
        for (int i = 0; i < 1100; i++) begin
            step();
            if (s_mon) mons++;
        end
        check("R7", "mon pulses in normal code", mons, 0);
        check("R4", "snk with lead div", int'(s_snk), 1);
        check("R4", "src with lead div", int'(s_src), 0);

        // lock: equal periods, divided edge 4 clocks ahead of reference
        do_reset();
        test_code = 3'b000; ratio = 16'd1024; ref_fast = 1'b1;
        vco_on = 1; vco_start = 2;
        ref_on = 1; ref_every = 16; rphase = 21;
        run_to(15960);
        check("R10", "lock after 15 comparisons", int'(s_lock), 0);
        run_to(17408);
        check("R10", "lock after 16 comparisons", int'(s_lock), 1);
        snks = 0; srcs = 0;
        for (int i = 0; i < 1024; i++) begin
            step();
            if (s_snk) snks++;
            if (s_src) srcs++;
        end
        check("R4", "sink width per comparison", snks, 4);
        check("R4", "source width per comparison", srcs, 0);
        rphase = rphase + 1;
        run_to(19600);
        check("R11", "lock after offset 5", int'(s_lock), 0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule